// File: doc/BRIEF.md
# UART Channel Interrupt Enable and Request Logic

This block turns the event and level indications of one serial channel into a single interrupt request. Its inputs come from the channel datapath: receive data available, transmit holding register empty, a line error pulse, a modem status change pulse, a pulse on receipt of an Xoff flow-control character, and the CTS and RTS pin levels. The CTS and RTS levels pass through a two-flop synchroniser before rising-edge detection. Event-type sources are latched as pending until the host performs the read that acknowledges them. Level-type sources are passed through as they are.

A host-writable 8-bit enable register masks each pending source. The masked sources are ORed into one request. A bus-mode input selects how that request leaves the block. In dedicated mode it drives an active-high per-channel output. In wired mode it drives an output-enable for an open-drain pad: the pad pulls the shared line low while the enable is set and releases the line otherwise. One enable bit does not mask any interrupt source. It selects sleep mode and is exported for use by other logic.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `sleep_en_o` is 0, and both `irq_o` and `irq_wor_oe_o` are 0.
- R2: A write to the enable register takes effect at the next clock edge. `ier_o` then returns the value last written, and `sleep_en_o` equals bit 4 of that value.
- R3: Bit 0 masks the receive-data-ready level and bit 1 masks the transmit-holding-empty level. Each level contributes to the request for as long as it is high.
- R4: Bit 2 masks the line error source. A pulse on `lsr_err_i` sets the source pending, and it stays pending until a cycle in which `lsr_rd_i` is high.
- R5: Bit 3 masks the modem status change source. A pulse on `msr_chg_i` sets the source pending, and it stays pending until a cycle in which `msr_rd_i` is high.
- R6: Bit 7 masks the CTS rising-edge source. A 0-to-1 change on `cts_i` sets this source pending at the third clock edge after the change. A falling edge has no effect. A read strobe on `msr_rd_i` clears the pending state.
- R7: Bit 6 masks the RTS rising-edge source. It behaves the same as the CTS source, with `rts_i` as the input.
- R8: Bit 5 masks the Xoff source. A pulse on `xoff_i` sets the source pending, and it stays pending until a cycle in which `int_ack_i` is high.
- R9: When a set pulse and its clear strobe arrive in the same cycle, the set wins and the source remains pending.
- R10: Clearing an enable bit removes that source from the request at the next edge. The pending state is kept, so setting the bit again restores the request without a new event.
- R11: When `bus_mode_i`=0 (dedicated), `irq_o` carries the request and `irq_wor_oe_o` is 0. When `bus_mode_i`=1 (wired), `irq_o` is 0 and `irq_wor_oe_o` carries the request.
- R12: Bit 4 (sleep) never raises a request on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | 0 selects the dedicated output, 1 selects the wired-OR output |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register read-back |
| rx_ready_i | input | 1 | Receive data available (level) |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| lsr_err_i | input | 1 | Line error event pulse |
| msr_chg_i | input | 1 | Modem status change event pulse |
| xoff_i | input | 1 | Xoff character received pulse |
| cts_i | input | 1 | CTS pin level (asynchronous) |
| rts_i | input | 1 | RTS signal level (asynchronous) |
| lsr_rd_i | input | 1 | Line status read strobe, clears the line error source |
| msr_rd_i | input | 1 | Modem status read strobe, clears the modem, CTS and RTS sources |
| int_ack_i | input | 1 | Interrupt identification read strobe, clears the Xoff source |
| sleep_en_o | output | 1 | Sleep mode enable (bit 4) |
| irq_o | output | 1 | Active-high dedicated interrupt request |
| irq_wor_oe_o | output | 1 | Pull-low enable for the shared open-drain request line |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the clock. They also assume that a clear strobe is an ordinary read indication, which may coincide with a set pulse. CTS and RTS may change at any time, and the synchroniser alone absorbs that timing. The stimulus changes every input just after a falling clock edge. It holds CTS and RTS steady through reset, and it pulses event and read strobes for exactly one cycle. The enable-masking sweep uses only the level sources, so every enable value can be applied without any latched state left over from earlier steps.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 8;
  localparam int SYNC_STAGES = 2;

  localparam int BIT_RXRDY = 0;
  localparam int BIT_THRE  = 1;
  localparam int BIT_LSR   = 2;
  localparam int BIT_MSR   = 3;
  localparam int BIT_SLEEP = 4;
  localparam int BIT_XOFF  = 5;
  localparam int BIT_RTS   = 6;
  localparam int BIT_CTS   = 7;

  // latched (event) sources, index into the pending block
  localparam int N_EVT   = 5;
  localparam int EVT_LSR  = 0;
  localparam int EVT_MSR  = 1;
  localparam int EVT_XOFF = 2;
  localparam int EVT_RTS  = 3;
  localparam int EVT_CTS  = 4;

  typedef enum logic {
    BUS_DEDICATED = 1'b0,
    BUS_WIRED     = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ier_o
);
  logic [W-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_q <= '0;
    else if (we_i) ier_q <= wdata_i;
  end

  assign ier_o = ier_q;

  p_ier_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ier_o == $past(wdata_i));
  p_ier_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ier_o));
endmodule

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= '0;
        else         sync_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= '0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // a detected edge lasts exactly one cycle
  p_rise_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (set_i[i]) pend_q <= 1'b1;  // set beats a same-cycle clear
      else if (clr_i[i]) pend_q <= 1'b0;
    end
    assign pend_o[i] = pend_q;

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]);
    p_pend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/uart_irq_req.sv
module uart_irq_req
  import uart_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] ier_i,
  input  logic         bus_mode_i,
  output logic         irq_o,
  output logic         irq_wor_oe_o
);
  logic req;
  bus_mode_e mode;

  assign mode = bus_mode_e'(bus_mode_i);
  assign req  = |(pend_i & ier_i);

  always_comb begin
    irq_o        = 1'b0;
    irq_wor_oe_o = 1'b0;
    if (mode == BUS_WIRED) irq_wor_oe_o = req;
    else                   irq_o        = req;
  end

  always_comb begin
    p_mode_excl_r11: assert (!(irq_o && irq_wor_oe_o));
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_mode_i,
  input  logic             ier_we_i,
  input  logic [IER_W-1:0] ier_wdata_i,
  output logic [IER_W-1:0] ier_o,
  input  logic             rx_ready_i,
  input  logic             thr_empty_i,
  input  logic             lsr_err_i,
  input  logic             msr_chg_i,
  input  logic             xoff_i,
  input  logic             cts_i,
  input  logic             rts_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             int_ack_i,
  output logic             sleep_en_o,
  output logic             irq_o,
  output logic             irq_wor_oe_o
);
  logic [IER_W-1:0] ier_q;
  logic [1:0]       pin_rise;  // [1]=cts, [0]=rts
  logic [N_EVT-1:0] evt_set, evt_clr, evt_pend;
  logic [IER_W-1:0] pend_vec;

  uart_irq_ier #(.W(IER_W)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ier_we_i),
    .wdata_i (ier_wdata_i),
    .ier_o   (ier_q)
  );

  uart_irq_edge #(.W(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cts_i, rts_i}),
    .rise_o (pin_rise)
  );

  always_comb begin
    evt_set = '0;
    evt_clr = '0;
    evt_set[EVT_LSR]  = lsr_err_i;
    evt_set[EVT_MSR]  = msr_chg_i;
    evt_set[EVT_XOFF] = xoff_i;
    evt_set[EVT_RTS]  = pin_rise[0];
    evt_set[EVT_CTS]  = pin_rise[1];
    evt_clr[EVT_LSR]  = lsr_rd_i;
    evt_clr[EVT_MSR]  = msr_rd_i;
    evt_clr[EVT_XOFF] = int_ack_i;
    evt_clr[EVT_RTS]  = msr_rd_i;
    evt_clr[EVT_CTS]  = msr_rd_i;
  end

  uart_irq_pending #(.N(N_EVT)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .pend_o (evt_pend)
  );

  always_comb begin
    pend_vec            = '0;
    pend_vec[BIT_RXRDY] = rx_ready_i;
    pend_vec[BIT_THRE]  = thr_empty_i;
    pend_vec[BIT_LSR]   = evt_pend[EVT_LSR];
    pend_vec[BIT_MSR]   = evt_pend[EVT_MSR];
    pend_vec[BIT_XOFF]  = evt_pend[EVT_XOFF];
    pend_vec[BIT_RTS]   = evt_pend[EVT_RTS];
    pend_vec[BIT_CTS]   = evt_pend[EVT_CTS];
  end

  uart_irq_req #(.W(IER_W)) u_req (
    .pend_i       (pend_vec),
    .ier_i        (ier_q),
    .bus_mode_i   (bus_mode_i),
    .irq_o        (irq_o),
    .irq_wor_oe_o (irq_wor_oe_o)
  );

  assign ier_o      = ier_q;
  assign sleep_en_o = ier_q[BIT_SLEEP];

  // only the masked sources other than sleep may raise a request
  p_sleep_silent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ier_q & evt_pend_masked()) == '0) |-> !(irq_o || irq_wor_oe_o));

  function automatic logic [IER_W-1:0] evt_pend_masked();
    logic [IER_W-1:0] m;
    m = pend_vec;
    m[BIT_SLEEP] = 1'b0;
    return m;
  endfunction

  p_disable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && ier_wdata_i == '0) |=> !(irq_o || irq_wor_oe_o));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_mode = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0, ier;
  logic rx = 0, thr = 0, lsr = 0, msr = 0, xoff = 0, cts = 0, rts = 0;
  logic lsr_rd = 0, msr_rd = 0, ack = 0;
  logic sleep_en, irq, oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_mode_i(bus_mode),
    .ier_we_i(we), .ier_wdata_i(wdata), .ier_o(ier),
    .rx_ready_i(rx), .thr_empty_i(thr), .lsr_err_i(lsr), .msr_chg_i(msr),
    .xoff_i(xoff), .cts_i(cts), .rts_i(rts),
    .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .int_ack_i(ack),
    .sleep_en_o(sleep_en), .irq_o(irq), .irq_wor_oe_o(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    we = 1'b1; wdata = v; tick(1); we = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  task automatic run();
    tick(3); rst_n = 1'b1; tick(1);
    // R1 reset state
    chk("R1 ier", ier, 8'h00);
    chk("R1 outputs", {5'd0, sleep_en, irq, oe}, 8'h00);

    // R2 readback sweep, R12 sleep bit alone never requests
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R2 readback", ier, v[7:0]);
      chk("R2 sleep_en", {7'd0, sleep_en}, {7'd0, v[4]});
    end
    wr(8'h10);
    chk("R12 sleep no irq", {7'd0, irq}, 8'h00);

    // R3 enable sweep over level sources
    for (int v = 0; v < 256; v++) begin
      for (int l = 0; l < 4; l++) begin
        wr(v[7:0]); rx = l[0]; thr = l[1]; tick(1);
        chk("R3 mask", {7'd0, irq}, {7'd0, (v[0] & l[0]) | (v[1] & l[1])});
      end
    end
    rx = 0; thr = 0; wr(8'h00);

    // R4 line error latch and clear
    wr(8'h04); pulse(lsr); tick(3);
    chk("R4 held", {7'd0, irq}, 8'h01);
    pulse(lsr_rd);
    chk("R4 cleared", {7'd0, irq}, 8'h00);

    // R9 set and clear together
    lsr = 1; lsr_rd = 1; tick(1); lsr = 0; lsr_rd = 0;
    chk("R9 set wins", {7'd0, irq}, 8'h01);

    // R10 mask keeps pending
    wr(8'h00);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(8'h04);
    chk("R10 restored", {7'd0, irq}, 8'h01);
    pulse(lsr_rd);

    // R11 wired mode
    bus_mode = 1; pulse(lsr);
    chk("R11 wired", {6'd0, irq, oe}, 8'h01);
    pulse(lsr_rd);
    chk("R11 wired released", {6'd0, irq, oe}, 8'h00);
    bus_mode = 0;

    // R5 modem status change
    wr(8'h08); pulse(msr); pulse(lsr_rd); pulse(ack);
    chk("R5 held", {7'd0, irq}, 8'h01);
    pulse(msr_rd);
    chk("R5 cleared", {7'd0, irq}, 8'h00);

    // R8 xoff
    wr(8'h20); pulse(xoff); pulse(msr_rd);
    chk("R8 held", {7'd0, irq}, 8'h01);
    pulse(ack);
    chk("R8 cleared", {7'd0, irq}, 8'h00);

    // R6 CTS rising edge, third edge after change
    wr(8'h80); cts = 1; tick(2);
    chk("R6 not yet", {7'd0, irq}, 8'h00);
    tick(1);
    chk("R6 set", {7'd0, irq}, 8'h01);
    pulse(msr_rd);
    chk("R6 cleared", {7'd0, irq}, 8'h00);
    cts = 0; tick(5);
    chk("R6 falling ignored", {7'd0, irq}, 8'h00);

    // R7 RTS rising edge, CTS enable off
    wr(8'h40); rts = 1; tick(2);
    chk("R7 not yet", {7'd0, irq}, 8'h00);
    tick(1);
    chk("R7 set", {7'd0, irq}, 8'h01);
    pulse(msr_rd); rts = 0; tick(5);
    chk("R7 falling ignored", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    fork
      run();
      begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule